// File: doc/BRIEF.md
# Halt-I/O Condition Code Controller

This block settles one Halt I/O request for an I/O subsystem with several channels and returns a two-bit condition code. The request carries five things: the channel and device lookup result, whether the device can take a halt, whether the channel is executing a command, and the channel's 16-bit status. From these the block picks one of four outcomes by fixed priority. An unreachable device comes first, a pending error condition second, a halt handed to the device third, and a forced buffer end with a status-word store last.

The request and the response each use a valid/ready handshake, and only one request is in flight at a time. When the device takes part, the block raises a halt request and waits for the device's reply and code for as long as needed. A status-word store is one masked 32-bit write to byte address 0x44. It updates only the upper halfword and leaves the lower halfword as it was.

Top module: `hio_halt_ctrl`

## Requirements
- R1: After reset the block is ready for a request (req_ready=1), and resp_valid, dev_halt_req, mem_wr_valid and buf_end_valid are all 0.
- R2: If req_chan_found=0 or req_dev_present=0, the response code is 3. No halt request, no memory write and no buffer-end pulse is issued, whatever the other request fields hold.
- R3: If the device is reachable and the status has any bit set under the error mask, the response code is 0, with no halt request, write or buffer-end pulse. The mask is bit 15 attention, bit 7 program-controlled interrupt, bit 6 program check, bit 5 protection check, bit 4 channel check and bit 1 exception (0x80F2).
- R4: If the device is reachable, no error bit is pending and req_dev_can_halt=1, dev_halt_req is raised and held until dev_halt_ack. The response code is the dev_halt_cc sampled with that ack, however many cycles the reply takes.
- R5: A device reply with code 1 causes exactly one memory write before the response, with mem_wr_addr=0x44, mem_wr_be=4'b1100 and mem_wr_data[31:16] equal to the status captured with the request. Any other device code causes no write.
- R6: In the fallback case (reachable, no error, no halt support) the response code is 1 and exactly one status-word write is made as in R5. If req_chan_busy=1, a one-cycle buf_end_valid pulse is also given with buf_end_chan equal to the request channel. If req_chan_busy=0, no pulse is given.
- R7: A response is held, with its code stable, until resp_ready. req_ready stays 0 from the accepted request until the response is taken.
- R8: A pending memory write holds its address, data and enables until mem_wr_ready.
- R9: Status bits outside the error mask (for example 0x0C00 or 0x0001) do not block the halt or fallback paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Halt I/O request present |
| req_ready | output | 1 | Block can accept a request |
| req_chan | input | CHAN_W | Channel index of the request |
| req_chan_found | input | 1 | Address maps to a channel |
| req_dev_present | input | 1 | A device exists at the address |
| req_dev_can_halt | input | 1 | Device offers a halt handshake |
| req_chan_busy | input | 1 | Channel is executing a command |
| req_status | input | 16 | Channel status |
| dev_halt_req | output | 1 | Halt request to the device |
| dev_halt_ack | input | 1 | Device reply strobe |
| dev_halt_cc | input | 2 | Device condition code |
| mem_wr_valid | output | 1 | Status-word write pending |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W | Byte address of the write |
| mem_wr_data | output | 32 | Write data |
| mem_wr_be | output | 4 | Byte enables |
| buf_end_valid | output | 1 | Mark channel buffer ended (pulse) |
| buf_end_chan | output | CHAN_W | Channel to mark |
| resp_valid | output | 1 | Condition code available |
| resp_ready | input | 1 | Requester takes the code |
| resp_cc | output | 2 | Condition code |

## Verification
Each wrong internal state shows up at the ports within the transaction that exposes it. A wrongly decoded outcome shows at once as the wrong response code, an unexpected halt request, or a missing or extra write. A captured status or channel that was latched wrongly shows up in the write data or in buf_end_chan on the first store. A state machine that skips its handshakes shows as a response that lets go before resp_ready, or as a write that drops before mem_wr_ready, within a cycle of the random stall.

// File: rtl/hio_pkg.sv
package hio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HALT  = 2'd1,
        ST_STORE = 2'd2,
        ST_RESP  = 2'd3
    } hio_state_e;

    typedef enum logic [1:0] {
        PATH_NODEV = 2'd0,
        PATH_ERR   = 2'd1,
        PATH_DEV   = 2'd2,
        PATH_FALL  = 2'd3
    } hio_path_e;

    localparam logic [1:0] CC_OK     = 2'd0;
    localparam logic [1:0] CC_STORED = 2'd1;
    localparam logic [1:0] CC_NODEV  = 2'd3;
endpackage

// File: rtl/hio_classify.sv
module hio_classify
    import hio_pkg::*;
#(
    parameter int          STAT_W   = 16,
    parameter logic [15:0] ERR_MASK = 16'h80F2
) (
    input  logic              chan_found,
    input  logic              dev_present,
    input  logic              dev_can_halt,
    input  logic [STAT_W-1:0] status,
    output hio_path_e         path
);
    logic err_pending;
    assign err_pending = |(status & ERR_MASK[STAT_W-1:0]);

    always_comb begin
        if (!chan_found || !dev_present) path = PATH_NODEV;
        else if (err_pending)            path = PATH_ERR;
        else if (dev_can_halt)           path = PATH_DEV;
        else                             path = PATH_FALL;
    end
endmodule

// File: rtl/hio_csw_fmt.sv
module hio_csw_fmt #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W/2-1:0] status,
    output logic [DATA_W-1:0]   data,
    output logic [DATA_W/8-1:0] be
);
    localparam int BYTES = DATA_W / 8;
    localparam int HALF  = DATA_W / 2;

    assign data = {status, {HALF{1'b0}}};

    for (genvar b = 0; b < BYTES; b++) begin : g_be
        assign be[b] = (b >= BYTES / 2);
    end
endmodule

// File: rtl/hio_halt_ctrl.sv
module hio_halt_ctrl
    import hio_pkg::*;
#(
    parameter int          CHAN_W   = 4,
    parameter int          ADDR_W   = 32,
    parameter int          DATA_W   = 32,
    parameter logic [31:0] CSW_ADDR = 32'h0000_0044,
    parameter logic [15:0] ERR_MASK = 16'h80F2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [CHAN_W-1:0]   req_chan,
    input  logic                req_chan_found,
    input  logic                req_dev_present,
    input  logic                req_dev_can_halt,
    input  logic                req_chan_busy,
    input  logic [15:0]         req_status,
    output logic                dev_halt_req,
    input  logic                dev_halt_ack,
    input  logic [1:0]          dev_halt_cc,
    output logic                mem_wr_valid,
    input  logic                mem_wr_ready,
    output logic [ADDR_W-1:0]   mem_wr_addr,
    output logic [DATA_W-1:0]   mem_wr_data,
    output logic [DATA_W/8-1:0] mem_wr_be,
    output logic                buf_end_valid,
    output logic [CHAN_W-1:0]   buf_end_chan,
    output logic                resp_valid,
    input  logic                resp_ready,
    output logic [1:0]          resp_cc
);
    localparam int STAT_W = DATA_W / 2;
    localparam int BYTES  = DATA_W / 8;
    localparam logic [BYTES-1:0] UPPER_BE = {{(BYTES/2){1'b1}}, {(BYTES/2){1'b0}}};

    typedef struct packed {
        hio_state_e        state;
        logic [CHAN_W-1:0] chan;
        logic [STAT_W-1:0] status;
        logic [1:0]        cc;
        logic              buf_end;
    } ctrl_t;

    ctrl_t     ctl_d, ctl_q;
    hio_path_e path;

    hio_classify #(.STAT_W(STAT_W), .ERR_MASK(ERR_MASK)) u_classify (
        .chan_found   (req_chan_found),
        .dev_present  (req_dev_present),
        .dev_can_halt (req_dev_can_halt),
        .status       (req_status[STAT_W-1:0]),
        .path         (path)
    );

    hio_csw_fmt #(.DATA_W(DATA_W)) u_fmt (
        .status (ctl_q.status),
        .data   (mem_wr_data),
        .be     (mem_wr_be)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.buf_end = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.chan   = req_chan;
                    ctl_d.status = req_status[STAT_W-1:0];
                    unique case (path)
                        PATH_NODEV: begin
                            ctl_d.cc    = CC_NODEV;
                            ctl_d.state = ST_RESP;
                        end
                        PATH_ERR: begin
                            ctl_d.cc    = CC_OK;
                            ctl_d.state = ST_RESP;
                        end
                        PATH_DEV: ctl_d.state = ST_HALT;
                        default: begin
                            ctl_d.cc      = CC_STORED;
                            ctl_d.buf_end = req_chan_busy;
                            ctl_d.state   = ST_STORE;
                        end
                    endcase
                end
            end
            ST_HALT: begin
                if (dev_halt_ack) begin
                    ctl_d.cc    = dev_halt_cc;
                    ctl_d.state = (dev_halt_cc == CC_STORED) ? ST_STORE : ST_RESP;
                end
            end
            ST_STORE: if (mem_wr_ready) ctl_d.state = ST_RESP;
            default:  if (resp_ready)   ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, chan: '0, status: '0, cc: '0, buf_end: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready     = (ctl_q.state == ST_IDLE);
    assign dev_halt_req  = (ctl_q.state == ST_HALT);
    assign mem_wr_valid  = (ctl_q.state == ST_STORE);
    assign mem_wr_addr   = CSW_ADDR[ADDR_W-1:0];
    assign buf_end_valid = ctl_q.buf_end;
    assign buf_end_chan  = ctl_q.chan;
    assign resp_valid    = (ctl_q.state == ST_RESP);
    assign resp_cc       = ctl_q.cc;

    // R7
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_ready |=> resp_valid && $stable(resp_cc));

    // R7
    one_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_data));

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_halt_req && !dev_halt_ack |=> dev_halt_req);

    // R5
    be_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> mem_wr_be == UPPER_BE);

    // R5
    store_then_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && mem_wr_ready |=> resp_valid && resp_cc == CC_STORED);

    // R6
    bufend_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_end_valid |-> mem_wr_valid);
endmodule

// File: tb/hio_halt_ctrl_test.sv
module hio_halt_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_chan = '0;
    logic        req_chan_found = 1'b0;
    logic        req_dev_present = 1'b0;
    logic        req_dev_can_halt = 1'b0;
    logic        req_chan_busy = 1'b0;
    logic [15:0] req_status = '0;
    logic        dev_halt_req;
    logic        dev_halt_ack = 1'b0;
    logic [1:0]  dev_halt_cc = '0;
    logic        mem_wr_valid;
    logic        mem_wr_ready = 1'b0;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic [3:0]  mem_wr_be;
    logic        buf_end_valid;
    logic [3:0]  buf_end_chan;
    logic        resp_valid;
    logic        resp_ready = 1'b0;
    logic [1:0]  resp_cc;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    hio_halt_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
        .req_chan_found(req_chan_found), .req_dev_present(req_dev_present),
        .req_dev_can_halt(req_dev_can_halt), .req_chan_busy(req_chan_busy),
        .req_status(req_status),
        .dev_halt_req(dev_halt_req), .dev_halt_ack(dev_halt_ack), .dev_halt_cc(dev_halt_cc),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
        .buf_end_valid(buf_end_valid), .buf_end_chan(buf_end_chan),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_cc(resp_cc)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    localparam logic [15:0] ERRM = 16'h80F2;

    function automatic int exp_path(input logic f, input logic d, input logic [15:0] s, input logic h);
        if (!f || !d) return 0;
        if ((s & ERRM) != 0) return 1;
        if (h) return 2;
        return 3;
    endfunction

    function automatic logic [1:0] exp_cc(input int p, input logic [1:0] dcc);
        case (p)
            0: return 2'd3;
            1: return 2'd0;
            2: return dcc;
            default: return 2'd1;
        endcase
    endfunction

    task automatic run(input logic f, input logic d, input logic h, input logic busy,
                       input logic [15:0] st, input logic [3:0] ch, input logic [1:0] dcc,
                       input int ack_dly, input int wr_dly, input int rsp_dly);
        int p = exp_path(f, d, st, h);
        int n_halt = 0, n_wr = 0, n_be = 0, wcnt = 0;
        logic [31:0] wdata = '0, waddr = '0;
        logic [3:0] wbe = '0, bchan = '0;
        logic [1:0] got_cc = '0;
        logic done = 1'b0;
        string tag = (p == 0) ? "R2" : (p == 1) ? "R3" : (p == 2) ? "R4" : "R6";
        @(negedge clk);
        req_chan_found = f; req_dev_present = d; req_dev_can_halt = h;
        req_chan_busy = busy; req_status = st; req_chan = ch; req_valid = 1'b1;
        for (int i = 0; i < 300 && !done; i++) begin
            if (req_valid && req_ready) begin
                @(negedge clk);
                req_valid = 1'b0;
                req_status = $urandom; req_chan = $urandom;
                req_chan_found = $urandom; req_dev_present = $urandom;
                req_dev_can_halt = $urandom; req_chan_busy = $urandom;
                continue;
            end
            dev_halt_ack = 1'b0; mem_wr_ready = 1'b0; resp_ready = 1'b0;
            if (buf_end_valid) begin n_be++; bchan = buf_end_chan; end
            if (dev_halt_req) begin
                if (wcnt == 0) n_halt++;
                if (wcnt >= ack_dly) begin dev_halt_ack = 1'b1; dev_halt_cc = dcc; wcnt = 0; end
                else wcnt++;
            end else if (mem_wr_valid) begin
                if (wcnt >= wr_dly) begin
                    mem_wr_ready = 1'b1; n_wr++; wdata = mem_wr_data;
                    waddr = mem_wr_addr; wbe = mem_wr_be; wcnt = 0;
                end else wcnt++;
            end else if (resp_valid) begin
                if (wcnt >= rsp_dly) begin resp_ready = 1'b1; got_cc = resp_cc; done = 1'b1; end
                else wcnt++;
            end
            @(negedge clk);
            dev_halt_ack = 1'b0; mem_wr_ready = 1'b0; resp_ready = 1'b0;
            dev_halt_cc = $urandom;
        end
        check({tag, " cc"}, {30'd0, got_cc}, {30'd0, exp_cc(p, dcc)});
        check({tag, " halt requests"}, n_halt, (p == 2) ? 1 : 0);
        if ((p == 2 && dcc == 2'd1) || p == 3) begin
            check("R5 write count", n_wr, 1);
            check("R5 write data", wdata, {st, 16'h0000});
            check("R5 write addr", waddr, 32'h44);
            check("R5 write be", {28'd0, wbe}, 32'd12);
        end else begin
            check({tag, " no write"}, n_wr, 0);
        end
        if (p == 3 && busy) begin
            check("R6 buf end pulse", n_be, 1);
            check("R6 buf end chan", {28'd0, bchan}, {28'd0, ch});
        end else begin
            check({tag, " no buf end"}, n_be, 0);
        end
        check("R7 ready after resp", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 req_ready", {31'd0, req_ready}, 32'd1);
        check("R1 resp_valid", {31'd0, resp_valid}, 32'd0);
        check("R1 dev_halt_req", {31'd0, dev_halt_req}, 32'd0);
        check("R1 mem_wr_valid", {31'd0, mem_wr_valid}, 32'd0);
        check("R1 buf_end_valid", {31'd0, buf_end_valid}, 32'd0);
        rst_n = 1'b1;
        // directed corners
        run(1'b0, 1'b1, 1'b1, 1'b1, 16'h80F2, 4'h3, 2'd1, 0, 0, 0); // R2 no channel beats error
        run(1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 4'h5, 2'd1, 0, 0, 2); // R2 no device
        run(1'b1, 1'b1, 1'b1, 1'b1, 16'h8000, 4'h6, 2'd1, 0, 0, 0); // R3 attention beats halt
        run(1'b1, 1'b1, 1'b0, 1'b1, 16'h0002, 4'h7, 2'd1, 0, 0, 0); // R3 exception bit
        run(1'b1, 1'b1, 1'b1, 1'b0, 16'h0C00, 4'h8, 2'd1, 9, 4, 3); // R4 R5 R9 slow device, cc1
        run(1'b1, 1'b1, 1'b1, 1'b0, 16'h0001, 4'h9, 2'd2, 0, 0, 0); // R4 R9 cc2, no write
        run(1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 4'hA, 2'd0, 3, 0, 0); // R4 cc0
        run(1'b1, 1'b1, 1'b0, 1'b1, 16'h0C01, 4'hB, 2'd0, 0, 7, 5); // R6 R8 R9 busy fallback
        run(1'b1, 1'b1, 1'b0, 1'b0, 16'h1234 & ~ERRM, 4'hC, 2'd0, 0, 0, 0); // R6 idle fallback
        // random mix
        for (int k = 0; k < 60; k++) begin
            logic [15:0] s = $urandom;
            if ($urandom_range(0, 2) != 0) s = s & ~ERRM;
            run(($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0), 1'($urandom),
                1'($urandom), s, 4'($urandom), 2'($urandom),
                $urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule